// File: doc/BRIEF.md
# Window Watchdog Timer

A supervisory timer that must be serviced inside a time slot, not merely before a deadline. A 7-bit counter counts down at a rate set by a fixed base divider and a 2-bit power-of-two select. Software services it by writing a new count, which is a refresh. A refresh is accepted only once the count has fallen to or below a programmable window value. A refresh made too early requests a system reset. So does letting the count fall out of the upper half of its range. An early-warning flag, which can raise an interrupt, marks the last count before that fall.

The block sits on the peripheral bus clock behind a simple register port with a single-cycle write strobe and a combinational read. It has three registers: control, configuration and status. Once enabled, the watchdog and its interrupt enable stay set until the system reset input clears them. The reset request output is a one-cycle pulse meant for the chip reset controller.

Top module: `window_watchdog`

## Requirements
- R1: After rst_ni, control reads 0x07F (disabled, count 0x7F), configuration reads 0x07F (window 0x7F, select 0, interrupt enable 0), status reads 0, and both outputs are low.
- R2: Register map: address 0 is control (count in bits 6:0, enable in bit 7). Address 1 is configuration (window in bits 6:0, rate select in bits 8:7, interrupt enable in bit 9). Address 2 is status (early-warning flag in bit 0). A write to control loads the count, which is a refresh.
- R3: The count drops by one every BASE << select clock cycles. A refresh clears the divider, so the first drop comes a full period after the write edge.
- R4: The count wraps from 0x00 to 0x7F. While disabled, the count still runs but never requests a reset.
- R5: The enable bit is set by writing 1 to control bit 7. Writing 0 there leaves it set.
- R6: When enabled, the count stepping from 0x40 to 0x3F raises the reset request for exactly one cycle, in the cycle after that step.
- R7: A control write that leaves the block enabled and loads a count below 0x40 requests a reset at once.
- R8: A refresh while enabled and while the current count is above the window requests a reset. A refresh at or below the window does not.
- R9: A window below 0x40 is legal. Any refresh made while the count is still at or above 0x40 then requests a reset.
- R10: The flag is set when the count steps down to 0x40, whether or not the interrupt is enabled. A status write with bit 0 = 0 clears it, and a write with bit 0 = 1 leaves it unchanged.
- R11: The interrupt enable is sticky like the enable bit. irq_o is high exactly when both the flag and the interrupt enable are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral bus clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| wr_addr_i | input | 2 | Write register address |
| wr_data_i | input | 10 | Write data |
| rd_addr_i | input | 2 | Read register address |
| rd_data_o | output | 10 | Combinational read data |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Early-warning interrupt |

## Verification
The bench builds the block with BASE set to 4 in place of 4096, so one count step lasts 4, 8, 16 or 32 clocks. With that setting, the bench can reach every rate select, the full walk from 0x7F to 0x40 and 0x3F, and the wrap through zero within a few hundred cycles. Each cycle count can still be predicted exactly. The default BASE changes only the divider width and the period length, not the control paths.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;
  localparam int CNT_W    = 7;
  localparam int SEL_W    = 2;
  localparam int ADDR_W   = 2;
  localparam int REG_W    = 10;
  localparam int EN_POS   = 7;
  localparam int PSEL_LSB = 7;
  localparam int IE_POS   = 9;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CFG  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

  typedef struct packed {
    logic             ie;
    logic [SEL_W-1:0] psel;
    logic [CNT_W-1:0] win;
  } cfg_t;
endpackage

// File: rtl/wwdg_prescaler.sv
module wwdg_prescaler #(
  parameter int unsigned BASE  = 4096,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             clear_i,
  output logic             tick_o
);
  localparam int unsigned MAX_DIV = BASE << ((1 << SEL_W) - 1);
  localparam int unsigned DIV_W   = $clog2(MAX_DIV);
  localparam int unsigned LIM_W   = DIV_W + 1;

  logic [DIV_W-1:0] div_q;
  logic [LIM_W-1:0] lim_m1;

  assign lim_m1 = (LIM_W'(BASE) << sel_i) - LIM_W'(1);
  // >= so that a select lowered mid-period still ticks promptly
  assign tick_o = ({1'b0, div_q} >= lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (clear_i || tick_o) div_q <= '0;
    else                        div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/wwdg_counter.sv
module wwdg_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             en_set_i,
  input  logic [CNT_W-1:0] win_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             en_o,
  output logic             fire_o,
  output logic             reach_o
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             en_nxt;

  assign en_nxt = en_q | (load_i & en_set_i);

  always_comb begin
    if (load_i)
      fire_o = (en_nxt && (load_val_i < HALF)) || (en_q && (cnt_q > win_i));
    else
      fire_o = tick_i && en_q && (cnt_q == HALF);
  end

  assign reach_o = tick_i && !load_i && (cnt_q == HALF + CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      en_q  <= 1'b0;
    end else begin
      en_q <= en_nxt;
      if (load_i)      cnt_q <= load_val_i;
      else if (tick_i) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign en_o  = en_q;

  assert_en_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);
endmodule

// File: rtl/wwdg_cfg.sv
module wwdg_cfg
  import wwdg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  input  logic             stat_we_i,
  input  logic             stat_wbit_i,
  input  logic             reach_i,
  output cfg_t             cfg_o,
  output logic             flag_o
);
  cfg_t cfg_q;
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.win  <= '1;
      cfg_q.psel <= '0;
      cfg_q.ie   <= 1'b0;
    end else if (cfg_we_i) begin
      cfg_q.win  <= cfg_wdata_i[CNT_W-1:0];
      cfg_q.psel <= cfg_wdata_i[PSEL_LSB +: SEL_W];
      cfg_q.ie   <= cfg_q.ie | cfg_wdata_i[IE_POS];
    end
  end

  // hardware set wins over a same-cycle software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       flag_q <= 1'b0;
    else if (reach_i)                  flag_q <= 1'b1;
    else if (stat_we_i && !stat_wbit_i) flag_q <= 1'b0;
  end

  assign cfg_o  = cfg_q;
  assign flag_o = flag_q;

  assert_ie_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.ie |=> cfg_q.ie);
  assert_flag_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(stat_we_i && !stat_wbit_i)) |=> flag_q);
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wwdg_pkg::*;
#(
  parameter int unsigned BASE = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              sys_rst_req_o,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W - 1);

  logic             ctrl_we, cfg_we, stat_we;
  logic             tick, fire, reach, en, flag, rst_req_q;
  logic [CNT_W-1:0] cnt;
  cfg_t             cfg;

  assign ctrl_we = wr_en_i && (wr_addr_i == A_CTRL);
  assign cfg_we  = wr_en_i && (wr_addr_i == A_CFG);
  assign stat_we = wr_en_i && (wr_addr_i == A_STAT);

  wwdg_prescaler #(.BASE(BASE), .SEL_W(SEL_W)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (cfg.psel),
    .clear_i (ctrl_we),
    .tick_o  (tick)
  );

  wwdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (ctrl_we),
    .load_val_i (wr_data_i[CNT_W-1:0]),
    .en_set_i   (wr_data_i[EN_POS]),
    .win_i      (cfg.win),
    .cnt_o      (cnt),
    .en_o       (en),
    .fire_o     (fire),
    .reach_o    (reach)
  );

  wwdg_cfg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we),
    .cfg_wdata_i (wr_data_i),
    .stat_we_i   (stat_we),
    .stat_wbit_i (wr_data_i[0]),
    .reach_i     (reach),
    .cfg_o       (cfg),
    .flag_o      (flag)
  );

  // request is one cycle wide even if causes arrive back to back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= fire && !rst_req_q;
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_CTRL:  rd_data_o[EN_POS:0] = {en, cnt};
      A_CFG:   rd_data_o = cfg;
      A_STAT:  rd_data_o[0] = flag;
      default: rd_data_o = '0;
    endcase
  end

  assign sys_rst_req_o = rst_req_q;
  assign irq_o         = flag & cfg.ie;

  assert_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |=> !sys_rst_req_o);
  assert_quiet_disabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !ctrl_we) |=> !sys_rst_req_o);
  assert_flag_at_half_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag) |-> (cnt == HALF));
  assert_irq_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag && cfg.ie));
endmodule

// File: tb/window_watchdog_bench.sv
module window_watchdog_bench;
  localparam int BASE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [9:0] rd_data;
  logic       rst_req, irq;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  window_watchdog #(.BASE(BASE)) u_window_watchdog (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .wr_en_i       (wr_en),
    .wr_addr_i     (wr_addr),
    .wr_data_i     (wr_data),
    .rd_addr_i     (rd_addr),
    .rd_data_o     (rd_data),
    .sys_rst_req_o (rst_req),
    .irq_o         (irq)
  );

  always @(negedge clk) if (rst_req) pulses++;

  // {select[1:0], load[6:0], wait[7:0], expected count[6:0]}
  localparam logic [23:0] VEC [6] = '{
    {2'd0, 7'h7F, 8'd8,  7'h7D},
    {2'd1, 7'h50, 8'd17, 7'h4E},
    {2'd2, 7'h45, 8'd33, 7'h43},
    {2'd3, 7'h20, 8'd31, 7'h20},
    {2'd0, 7'h01, 8'd8,  7'h7F},
    {2'd0, 7'h42, 8'd8,  7'h40}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  initial begin
    int v;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 'h07F);
    rd(2'd1, v); check("R1 cfg", v, 'h07F);
    rd(2'd2, v); check("R1 status", v, 0);
    check("R1 rst_req", int'(rst_req), 0);
    check("R1 irq", int'(irq), 0);

    // R3 R4 rate and wrap, disabled
    foreach (VEC[i]) begin
      wr(2'd1, {1'b0, VEC[i][23:22], 7'h7F});
      wr(2'd0, {3'b000, VEC[i][21:15]});
      step(int'(VEC[i][14:7]));
      rd(2'd0, v);
      check($sformatf("R3 vector %0d count", i), v, int'(VEC[i][6:0]));
    end
    check("R4 no reset while disabled", pulses, 0);

    // R10 flag set without interrupt enable; write 1 ignored, write 0 clears
    rd(2'd2, v); check("R10 flag set at 0x40", v, 1);
    check("R11 irq gated by enable", int'(irq), 0);
    wr(2'd2, 10'h001);
    rd(2'd2, v); check("R10 write 1 no effect", v, 1);
    wr(2'd2, 10'h000);
    rd(2'd2, v); check("R10 write 0 clears", v, 0);

    // R5 enable and stickiness
    wr(2'd1, 10'h07F);
    wr(2'd0, 10'h0FF);
    step(2);
    check("R5 enable write no reset", pulses, 0);
    wr(2'd0, 10'h07F);
    step(2);
    rd(2'd0, v); check("R5 enable sticky", (v >> 7) & 1, 1);
    check("R8 refresh at window 0x7F ok", pulses, 0);

    // R8 early refresh
    wr(2'd1, 10'h050);
    wr(2'd0, 10'h0FF);
    step(2);
    check("R8 early refresh resets", pulses, 1);
    step(200);
    wr(2'd0, 10'h0FF);
    step(2);
    check("R8 refresh in window ok", pulses, 1);
    rd(2'd0, v); check("R2 refresh reload", v, 'h0FF);

    // R6 R10 R11 rollover with interrupt enabled
    wr(2'd1, 10'h27F);
    wr(2'd0, 10'h0FF);
    step(252);
    rd(2'd0, v); check("R10 count at 0x40", v, 'h0C0);
    rd(2'd2, v); check("R10 flag at 0x40", v, 1);
    check("R11 irq raised", int'(irq), 1);
    check("R6 no reset before step", pulses, 1);
    step(4);
    check("R6 reset on 0x40 to 0x3F", pulses, 2);
    rd(2'd0, v); check("R6 count 0x3F", v, 'h0BF);
    wr(2'd1, 10'h07F);
    rd(2'd1, v); check("R11 ie sticky", v, 'h27F);
    wr(2'd2, 10'h000);
    check("R11 irq drops with flag", int'(irq), 0);

    // R7 immediate reset on low load
    wr(2'd0, 10'h0B0);
    step(2);
    check("R7 low load resets", pulses, 3);

    // R9 window below 0x40
    wr(2'd1, 10'h03F);
    wr(2'd0, 10'h0FF);
    step(2);
    check("R9 refresh from 0x30 ok", pulses, 3);
    wr(2'd0, 10'h0FF);
    step(2);
    check("R9 refresh above low window resets", pulses, 4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule